// File: doc/BRIEF.md
# Interrupt Status, Enable and Keyed Reset Register Block

This block collects eight raw event lines from a serial-bus controller, latches each into a sticky status bit, and raises one interrupt line when any latched event is also enabled and the master interrupt switch is on. Software sees four registers through a plain write strobe, an address and a write-data word. Read data is returned combinationally for the current address.

The four registers are as follows. The status register is cleared by writing a mask, where each 1 clears its bit. The per-source enable register is ordinary read/write. The master switch is a single bit at position 31. A reset register only acts when it is written with the key value 0xA, and it then emits a single-cycle reset pulse towards the rest of the controller.

The interrupt output is registered, so it follows the pending set one clock later. A source that fires in the same cycle as a clear of its own bit wins over the clear, so no event is lost between the software read and its clear write.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After reset, status, enable and the master switch all read 0, and `irq_o` and `srst_o` are low.
- R2: An event on `src_evt[i]` sets status bit i at the next clock edge. The bit stays set until it is cleared, and status is read at offset 0x20 in bits [7:0]. The bit order is: 0 arbitration lost, 1 transmit error or done, 2 transmit empty, 3 receive at watermark, 4 bus idle, 5 addressed as target, 6 no longer addressed, 7 transmit half empty.
- R3: A write to offset 0x20 clears every status bit whose write-data bit is 1 and leaves every other status bit unchanged.
- R4: If `src_evt[i]` is high in the same cycle as a clear write that covers bit i, status bit i remains set.
- R5: Offset 0x28 holds the enable mask in bits [7:0]. It is written as a whole, and bits [31:8] read as 0.
- R6: Offset 0x1C holds the master switch in bit 31. Writes store only bit 31, and every other bit reads as 0.
- R7: `irq_o` in a cycle equals, from the previous cycle, the master switch ANDed with the OR of (status AND enable). A new event therefore shows on `irq_o` two edges after it is presented.
- R8: `irq_o` drops one cycle after the last pending bit is cleared, after that bit is masked in the enable register, or after the master switch is turned off.
- R9: A write of exactly 0x0000000A to offset 0x40 drives `srst_o` high for exactly the one cycle that follows the write.
- R10: A write to offset 0x40 with any other value leaves `srst_o` low and changes no register.
- R11: Offset 0x40 and all unmapped offsets read 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| src_evt | input | SRC_N (8) | Raw event pulses, one per source |
| irq_o | output | 1 | Registered interrupt request |
| srst_o | output | 1 | One-cycle soft reset pulse |

## Verification
The bench builds the block with its default values: eight sources, 8-bit offsets, a 32-bit data word and the key 0xA. With these values every source bit, the bit-31 master switch and the full-word key compare can be reached from the register offsets. A table walks the status, enable and master-switch paths, including a clear that collides with a new event, a masked source and a write to an unmapped offset. Directed steps then measure the interrupt latency in both directions, the width of the reset pulse, and the rejection of a near-miss key such as 0x1A.

// File: rtl/irqblk_pkg.sv
package irqblk_pkg;

    // Which register an address selects
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GIE,
        SEL_STAT,
        SEL_EN,
        SEL_RST
    } reg_sel_e;

endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] stat_o
);

    typedef struct packed {
        logic [N-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    // Per-bit next state: a new event dominates a clear of the same bit
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            st_d.stat[i] = ev_i[i] | (st_q.stat[i] & ~(clr_we_i & clr_mask_i[i]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;

endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we_i,
    input  logic [N-1:0] en_wdata_i,
    input  logic         gie_we_i,
    input  logic         gie_wdata_i,
    input  logic [N-1:0] stat_i,
    output logic [N-1:0] en_o,
    output logic         gie_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] en;
        logic         gie;
        logic         irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we_i)  st_d.en  = en_wdata_i;
        if (gie_we_i) st_d.gie = gie_wdata_i;
        // Output follows the settled pending set one cycle later
        st_d.irq = st_q.gie & (|(stat_i & st_q.en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign gie_o = st_q.gie;
    assign irq_o = st_q.irq;

endmodule

// File: rtl/srst_keygen.sv
module srst_keygen #(
    parameter int unsigned     DW  = 32,
    parameter logic [DW-1:0]   KEY = 'hA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic          pulse_o
);

    typedef struct packed {
        logic pulse;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.pulse = we_i && (wdata_i == KEY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irqblk_pkg::*;
#(
    parameter int unsigned         SRC_N    = 8,
    parameter int unsigned         ADDR_W   = 8,
    parameter int unsigned         DATA_W   = 32,
    parameter int unsigned         GIE_BIT  = 31,
    parameter logic [ADDR_W-1:0]   GIE_OFS  = 'h1C,
    parameter logic [ADDR_W-1:0]   STAT_OFS = 'h20,
    parameter logic [ADDR_W-1:0]   EN_OFS   = 'h28,
    parameter logic [ADDR_W-1:0]   RST_OFS  = 'h40,
    parameter logic [DATA_W-1:0]   RST_KEY  = 'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_N-1:0]  src_evt,
    output logic              irq_o,
    output logic              srst_o
);

    reg_sel_e         sel;
    logic [SRC_N-1:0] stat_w;
    logic [SRC_N-1:0] en_w;
    logic             gie_w;

    always_comb begin
        if      (bus_addr == GIE_OFS)  sel = SEL_GIE;
        else if (bus_addr == STAT_OFS) sel = SEL_STAT;
        else if (bus_addr == EN_OFS)   sel = SEL_EN;
        else if (bus_addr == RST_OFS)  sel = SEL_RST;
        else                           sel = SEL_NONE;
    end

    irq_stat_bank #(.N(SRC_N)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (src_evt),
        .clr_we_i   (bus_we && sel == SEL_STAT),
        .clr_mask_i (bus_wdata[SRC_N-1:0]),
        .stat_o     (stat_w)
    );

    irq_mask_gate #(.N(SRC_N)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_we_i     (bus_we && sel == SEL_EN),
        .en_wdata_i  (bus_wdata[SRC_N-1:0]),
        .gie_we_i    (bus_we && sel == SEL_GIE),
        .gie_wdata_i (bus_wdata[GIE_BIT]),
        .stat_i      (stat_w),
        .en_o        (en_w),
        .gie_o       (gie_w),
        .irq_o       (irq_o)
    );

    srst_keygen #(.DW(DATA_W), .KEY(RST_KEY)) u_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we && sel == SEL_RST),
        .wdata_i (bus_wdata),
        .pulse_o (srst_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_GIE:  bus_rdata[GIE_BIT]   = gie_w;
            SEL_STAT: bus_rdata[SRC_N-1:0] = stat_w;
            SEL_EN:   bus_rdata[SRC_N-1:0] = en_w;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_ctrl_regs_chk.sv
module irq_ctrl_regs_chk #(
    parameter int unsigned         SRC_N    = 8,
    parameter int unsigned         ADDR_W   = 8,
    parameter int unsigned         DATA_W   = 32,
    parameter logic [ADDR_W-1:0]   STAT_OFS = 'h20,
    parameter logic [ADDR_W-1:0]   RST_OFS  = 'h40,
    parameter logic [DATA_W-1:0]   RST_KEY  = 'hA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [SRC_N-1:0]  src_evt,
    input logic              irq_o,
    input logic              srst_o,
    input logic [SRC_N-1:0]  stat_q,
    input logic [SRC_N-1:0]  en_q,
    input logic              gie_q
);

    logic key_wr;
    logic clr_wr;
    assign key_wr = bus_we && (bus_addr == RST_OFS) && (bus_wdata == RST_KEY);
    assign clr_wr = bus_we && (bus_addr == STAT_OFS);

    // R2 R4
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> ((stat_q & $past(src_evt)) == $past(src_evt)));

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((stat_q & $past(bus_wdata[SRC_N-1:0] & ~src_evt)) == '0));

    // R7 R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(gie_q && ((stat_q & en_q) != '0))));

    // R9
    srst_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> srst_o);

    // R9
    srst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> !srst_o || $past(key_wr));

    // R10
    srst_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> !srst_o);

endmodule

bind irq_ctrl_regs irq_ctrl_regs_chk #(
    .SRC_N    (SRC_N),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STAT_OFS (STAT_OFS),
    .RST_OFS  (RST_OFS),
    .RST_KEY  (RST_KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .src_evt   (src_evt),
    .irq_o     (irq_o),
    .srst_o    (srst_o),
    .stat_q    (stat_w),
    .en_q      (en_w),
    .gie_q     (gie_w)
);

// File: tb/sim_irq_ctrl_regs.sv
`timescale 1ns/1ps
module sim_irq_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  src_evt = '0;
    logic        irq_o;
    logic        srst_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl_regs u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_evt   (src_evt),
        .irq_o     (irq_o),
        .srst_o    (srst_o)
    );

    localparam logic [7:0] A_GIE = 8'h1C, A_STAT = 8'h20, A_EN = 8'h28, A_RST = 8'h40;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [7:0]  ev;
        logic [7:0]  st;
        logic        irq;
        logic [3:0]  req;
    } row_t;

    localparam int NROW = 14;
    localparam row_t TBL [NROW] = '{
        '{1'b1, 8'h28, 32'h0000_00FF, 8'h00, 8'h00, 1'b0, 4'd5},   // R5 enable all
        '{1'b1, 8'h1C, 32'h8000_0000, 8'h00, 8'h00, 1'b0, 4'd6},   // R6 switch on
        '{1'b0, 8'h00, 32'h0000_0000, 8'h05, 8'h05, 1'b1, 4'd2},   // R2 two sources
        '{1'b1, 8'h20, 32'h0000_0001, 8'h00, 8'h04, 1'b1, 4'd3},   // R3 partial clear
        '{1'b1, 8'h20, 32'h0000_0004, 8'h80, 8'h80, 1'b1, 4'd3},   // R3 clear + other event
        '{1'b1, 8'h28, 32'h0000_007F, 8'h00, 8'h80, 1'b0, 4'd8},   // R8 masked
        '{1'b1, 8'h28, 32'h0000_00FF, 8'h00, 8'h80, 1'b1, 4'd7},   // R7 unmasked
        '{1'b1, 8'h1C, 32'h7FFF_FFFF, 8'h00, 8'h80, 1'b0, 4'd8},   // R8 switch off
        '{1'b1, 8'h1C, 32'h8000_0000, 8'h00, 8'h80, 1'b1, 4'd7},   // R7 switch on
        '{1'b1, 8'h20, 32'h0000_00FF, 8'h20, 8'h20, 1'b1, 4'd4},   // R4 set beats clear
        '{1'b1, 8'h20, 32'h0000_0020, 8'h00, 8'h00, 1'b0, 4'd8},   // R8 last cleared
        '{1'b1, 8'h40, 32'h0000_0005, 8'h00, 8'h00, 1'b0, 4'd10},  // R10 wrong key
        '{1'b1, 8'h30, 32'h0000_00FF, 8'h40, 8'h40, 1'b1, 4'd11},  // R11 unmapped write
        '{1'b1, 8'h20, 32'h0000_0040, 8'h00, 8'h00, 1'b0, 4'd3}    // R3 clear to zero
    };

    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev);
        bus_we = we; bus_addr = a; bus_wdata = d; src_evt = ev;
        @(negedge clk);
        bus_we = 1'b0; src_evt = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_STAT, v); chk("R1 status", v, 32'h0);
        rd(A_EN, v);   chk("R1 enable", v, 32'h0);
        rd(A_GIE, v);  chk("R1 switch", v, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 srst", {31'b0, srst_o}, 32'h0);

        // Table walk: apply row, one idle cycle, then check status and irq
        for (int i = 0; i < NROW; i++) begin
            cyc(TBL[i].we, TBL[i].addr, TBL[i].wd, TBL[i].ev);
            cyc(1'b0, 8'h00, 32'h0, 8'h00);
            rd(A_STAT, v);
            chk($sformatf("R%0d row %0d status", TBL[i].req, i), v, {24'b0, TBL[i].st});
            chk($sformatf("R%0d row %0d irq", TBL[i].req, i), {31'b0, irq_o}, {31'b0, TBL[i].irq});
        end

        // R5 upper bits of enable read zero
        cyc(1'b1, A_EN, 32'hFFFF_FFFF, 8'h00);
        rd(A_EN, v); chk("R5 enable width", v, 32'h0000_00FF);

        // R6 only bit 31 of the switch is stored
        cyc(1'b1, A_GIE, 32'hFFFF_FFFF, 8'h00);
        rd(A_GIE, v); chk("R6 switch width", v, 32'h8000_0000);

        // R7 latency: status visible after one edge, irq after two
        cyc(1'b0, 8'h00, 32'h0, 8'h02);
        rd(A_STAT, v); chk("R2 status after event", v, 32'h02);
        chk("R7 irq not yet", {31'b0, irq_o}, 32'h0);
        cyc(1'b0, 8'h00, 32'h0, 8'h00);
        chk("R7 irq raised", {31'b0, irq_o}, 32'h1);

        // R8 drop one cycle after the clear
        cyc(1'b1, A_STAT, 32'h0000_0002, 8'h00);
        chk("R8 irq still high", {31'b0, irq_o}, 32'h1);
        cyc(1'b0, 8'h00, 32'h0, 8'h00);
        chk("R8 irq dropped", {31'b0, irq_o}, 32'h0);

        // R9 key write gives one-cycle pulse
        chk("R9 srst idle", {31'b0, srst_o}, 32'h0);
        cyc(1'b1, A_RST, 32'h0000_000A, 8'h00);
        chk("R9 srst high", {31'b0, srst_o}, 32'h1);
        cyc(1'b0, 8'h00, 32'h0, 8'h00);
        chk("R9 srst one cycle", {31'b0, srst_o}, 32'h0);

        // R10 near-miss key ignored, registers untouched
        cyc(1'b1, A_RST, 32'h0000_001A, 8'h00);
        chk("R10 srst low", {31'b0, srst_o}, 32'h0);
        rd(A_EN, v);  chk("R10 enable kept", v, 32'h0000_00FF);
        rd(A_GIE, v); chk("R10 switch kept", v, 32'h8000_0000);

        // R11 reset and unmapped offsets read zero
        rd(A_RST, v); chk("R11 reset reads zero", v, 32'h0);
        rd(8'h3C, v); chk("R11 unmapped reads zero", v, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule